// File: doc/BRIEF.md
# Hidden DAC Control Register Sequencer

The sequencer stands in front of the pixel mask register of a palette DAC. It also guards a second, hidden control register that sits behind the same I/O port. Software reaches the hidden register by reading the mask port several times in a row. An internal counter tracks these back-to-back mask reads. Any access to one of the other palette ports (read index, write index, palette data) resets that counter. Once enough consecutive reads have been seen, the mask port is steered to the hidden register: a read returns the hidden value, and a write stores into it.

An extensions-unlock input gates the whole mechanism. While extensions are locked, the mask port behaves as a plain mask register. A chip-variant input selects between two behaviours once the hidden register has been reached. In the first, a read there re-arms the sequence. In the second, the port stays steered to the hidden register until some other access breaks the run. The block drives the current pixel mask and hidden register value to the rest of the DAC. It returns read data combinationally in the same cycle as the read strobe.

Top module: `dac_hidden_seq`

## Requirements
- R1: Reset leaves the run counter at 0, the pixel mask at 0xFF and the hidden register at 0x00. The first mask read after reset therefore returns 0xFF.
- R2: Port select encoding is: 0 = mask port, 1 = read-index port, 2 = write-index port, 3 = palette-data port. `rd_data` returns 0x00 for a read of ports 1 to 3 and whenever no read strobe is active.
- R3: While `ext_unlock` is low, mask-port reads return the pixel mask and leave the counter unchanged.
- R4: With extensions unlocked, each mask read made while the counter is below 4 adds one to the counter. Reads made at counts 0, 1 and 2 return the pixel mask. The read made at count 3, which brings the counter to 4, already returns the hidden register.
- R5: With `sticky_variant` low, a mask read at count 4 returns the hidden register and clears the counter to 0. The next mask read therefore returns the pixel mask.
- R6: With `sticky_variant` high, a mask read at count 4 returns the hidden register and leaves the counter at 4, so every further mask read keeps returning it. The counter never goes above 4.
- R7: A read or a write of port 1, 2 or 3 clears the counter to 0.
- R8: A mask-port write made while extensions are unlocked and the counter is 4 stores the data into the hidden register, leaves the pixel mask unchanged, and clears the counter to 0.
- R9: Any other mask-port write stores the data into the pixel mask, leaves the hidden register unchanged, and clears the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 2 | Palette port select (0 mask, 1 read index, 2 write index, 3 data) |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| ext_unlock | input | 1 | High when extended registers are unlocked |
| sticky_variant | input | 1 | High selects the variant that holds the count after reaching the hidden register |
| rd_data | output | 8 | Read data, valid in the cycle of `io_rd` |
| pix_mask | output | 8 | Current pixel mask value |
| hidden_ctrl | output | 8 | Current hidden control register value |

## Verification
The assertions assume that a read strobe and a write strobe never arrive in the same cycle. They also assume that each strobe marks exactly one access per clock cycle. The stimulus respects both assumptions: each access is driven for a single cycle with only one strobe raised. The mode inputs `ext_unlock` and `sticky_variant` are changed only in idle cycles between accesses, so no property sees a mode switch in the middle of an access.

// File: rtl/dac_hseq_pkg.sv
package dac_hseq_pkg;

  typedef enum logic [1:0] {
    PORT_MASK = 2'd0,
    PORT_RIDX = 2'd1,
    PORT_WIDX = 2'd2,
    PORT_DATA = 2'd3
  } dac_port_e;

  function automatic logic is_mask_port(input logic [1:0] sel);
    return dac_port_e'(sel) == PORT_MASK;
  endfunction

endpackage

// File: rtl/dac_port_decode.sv
module dac_port_decode
  import dac_hseq_pkg::*;
(
  input  logic [1:0] io_sel,
  input  logic       io_rd,
  input  logic       io_wr,
  output logic       mask_rd,
  output logic       mask_wr,
  output logic       other_acc
);

  logic sel_mask;

  always_comb begin
    sel_mask  = is_mask_port(io_sel);
    mask_rd   = io_rd && sel_mask;
    mask_wr   = io_wr && sel_mask;
    other_acc = (io_rd || io_wr) && !sel_mask;
  end

endmodule

// File: rtl/dac_read_counter.sv
module dac_read_counter #(
  parameter int LIMIT = 4,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_rd,
  input  logic          mask_wr,
  input  logic          other_acc,
  input  logic          unlocked,
  input  logic          sticky,
  output logic [CW-1:0] cnt,
  output logic          hidden_rd,
  output logic          hidden_wr
);

  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);
  localparam logic [CW-1:0] PRE_C = CW'(LIMIT - 1);

  function automatic logic [CW-1:0] next_count(
    input logic [CW-1:0] cur,
    input logic          rd, wr, oth, unl, stk
  );
    if (oth || wr)      return '0;
    if (!(rd && unl))   return cur;
    if (cur == LIM_C)   return stk ? LIM_C : '0;
    return cur + 1'b1;
  endfunction

  logic [CW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt   = next_count(cnt, mask_rd, mask_wr, other_acc, unlocked, sticky);
    hidden_rd = mask_rd && unlocked && (cnt >= PRE_C);
    hidden_wr = mask_wr && unlocked && (cnt == LIM_C);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R6
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM_C);

  // R7
  other_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    other_acc |=> cnt == '0);

  // R3
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rd && !mask_wr && !other_acc && !unlocked) |=> $stable(cnt));

  // R4
  climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rd && !mask_wr && unlocked && cnt < LIM_C) |=> cnt == $past(cnt) + 1'b1);

  // R5
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rd && !mask_wr && unlocked && !sticky && cnt == LIM_C) |=> cnt == '0);

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rd && !mask_wr && unlocked && sticky && cnt == LIM_C) |=> cnt == LIM_C);

  // R8
  wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> cnt == '0);

endmodule

// File: rtl/dac_mask_regs.sv
module dac_mask_regs #(
  parameter int             DW       = 8,
  parameter logic [DW-1:0]  MASK_RST = '1,
  parameter logic [DW-1:0]  CTRL_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_rd,
  input  logic          mask_wr,
  input  logic          hidden_rd,
  input  logic          hidden_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] pix_mask,
  output logic [DW-1:0] hidden_ctrl,
  output logic [DW-1:0] rd_data
);

  logic mask_store;

  always_comb begin
    mask_store = mask_wr && !hidden_wr;
    if (!mask_rd)       rd_data = '0;
    else if (hidden_rd) rd_data = hidden_ctrl;
    else                rd_data = pix_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_mask    <= MASK_RST;
      hidden_ctrl <= CTRL_RST;
    end else begin
      if (mask_store) pix_mask    <= wdata;
      if (hidden_wr)  hidden_ctrl <= wdata;
    end
  end

  // R8
  hidden_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hidden_wr |=> (hidden_ctrl == $past(wdata)) && $stable(pix_mask));

  // R9
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !hidden_wr) |=> (pix_mask == $past(wdata)) && $stable(hidden_ctrl));

  // R2
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_rd |-> rd_data == '0);

endmodule

// File: rtl/dac_hidden_seq.sv
module dac_hidden_seq #(
  parameter int            DW        = 8,
  parameter int            UNLOCK_N  = 4,
  parameter logic [DW-1:0] MASK_RST  = '1,
  parameter logic [DW-1:0] CTRL_RST  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    io_sel,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [DW-1:0] io_wdata,
  input  logic          ext_unlock,
  input  logic          sticky_variant,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] pix_mask,
  output logic [DW-1:0] hidden_ctrl
);

  localparam int CW = $clog2(UNLOCK_N + 1);

  logic          ev_mask_rd;
  logic          ev_mask_wr;
  logic          ev_other;
  logic          ev_hidden_rd;
  logic          ev_hidden_wr;
  logic [CW-1:0] run_cnt;

  dac_port_decode u_dec (
    .io_sel    (io_sel),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .mask_rd   (ev_mask_rd),
    .mask_wr   (ev_mask_wr),
    .other_acc (ev_other)
  );

  dac_read_counter #(.LIMIT(UNLOCK_N), .CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_rd   (ev_mask_rd),
    .mask_wr   (ev_mask_wr),
    .other_acc (ev_other),
    .unlocked  (ext_unlock),
    .sticky    (sticky_variant),
    .cnt       (run_cnt),
    .hidden_rd (ev_hidden_rd),
    .hidden_wr (ev_hidden_wr)
  );

  dac_mask_regs #(.DW(DW), .MASK_RST(MASK_RST), .CTRL_RST(CTRL_RST)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_rd     (ev_mask_rd),
    .mask_wr     (ev_mask_wr),
    .hidden_rd   (ev_hidden_rd),
    .hidden_wr   (ev_hidden_wr),
    .wdata       (io_wdata),
    .pix_mask    (pix_mask),
    .hidden_ctrl (hidden_ctrl),
    .rd_data     (rd_data)
  );

  // input assumption: one strobe per cycle
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr));

  // R1
  rst_cnt_chk: assert property (@(posedge clk)
    !rst_n |=> run_cnt == '0);

endmodule

// File: tb/dac_hidden_seq_tb.sv
module dac_hidden_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] io_sel = '0;
  logic       io_rd = 1'b0;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic       ext_unlock = 1'b0;
  logic       sticky_variant = 1'b0;
  logic [7:0] rd_data, pix_mask, hidden_ctrl;

  always #4 clk = ~clk;

  dac_hidden_seq dut_i (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .ext_unlock(ext_unlock), .sticky_variant(sticky_variant),
    .rd_data(rd_data), .pix_mask(pix_mask), .hidden_ctrl(hidden_ctrl)
  );

  typedef struct {
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t sb[$];
  int   n_cmp = 0;
  int   n_bad = 0;

  // bench model of the requirements
  int         m_cnt = 0;
  logic [7:0] m_mask = 8'hFF;
  logic [7:0] m_hid = 8'h00;
  logic       m_unl = 1'b0;
  logic       m_stk = 1'b0;

  task automatic compare(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic rd, input logic wr, input logic [1:0] sel,
                       input logic [7:0] d, input string req);
    exp_t e;
    @(negedge clk);
    if (rd) begin
      e.req = req;
      if (sel == 2'd0) begin
        if (m_unl) begin
          e.val = (m_cnt >= 3) ? m_hid : m_mask;
          if (m_cnt == 4) m_cnt = m_stk ? 4 : 0;
          else            m_cnt = m_cnt + 1;
        end else begin
          e.val = m_mask;
        end
      end else begin
        e.val = 8'h00;
        m_cnt = 0;
      end
      sb.push_back(e);
    end else if (wr) begin
      if (sel == 2'd0) begin
        if (m_unl && m_cnt == 4) m_hid = d;
        else                     m_mask = d;
      end
      m_cnt = 0;
    end
    io_rd = rd; io_wr = wr; io_sel = sel; io_wdata = d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 2'd0, 8'h00, "");
  endtask

  task automatic rd_mask(input int n, input string req);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 2'd0, 8'h00, req);
  endtask

  task automatic set_mode(input logic u, input logic s);
    idle();
    ext_unlock = u; sticky_variant = s; m_unl = u; m_stk = s;
  endtask

  task automatic check_regs(input string req);
    idle();
    #2;
    compare(pix_mask, m_mask, {req, " pix_mask"});
    compare(hidden_ctrl, m_hid, {req, " hidden_ctrl"});
  endtask

  // monitor: pops the scoreboard for every read strobe
  always @(negedge clk) begin
    #2;
    if (rst_n && io_rd) begin
      if (sb.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: actual 0x%02h expected none", rd_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        compare(rd_data, e.val, e.req);
      end
    end else if (rst_n && !io_wr) begin
      compare(rd_data, 8'h00, "R2 idle");
    end
  end

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    compare(pix_mask, 8'hFF, "R1 reset mask");
    compare(hidden_ctrl, 8'h00, "R1 reset hidden");
    @(negedge clk);
    rst_n = 1'b1;
    check_regs("R1");
    rd_mask(1, "R1 first read");
    drive(1'b1, 1'b0, 2'd1, 8'h00, "R2 read-index read");
    drive(1'b1, 1'b0, 2'd3, 8'h00, "R2 data read");
    drive(1'b0, 1'b1, 2'd0, 8'h3C, "R9");
    check_regs("R9 plain write");

    // locked: no counting
    rd_mask(6, "R3 locked read");
    set_mode(1'b1, 1'b0);
    rd_mask(4, "R4 climb");
    drive(1'b0, 1'b1, 2'd0, 8'hA5, "R8");
    check_regs("R8 hidden write");
    rd_mask(4, "R4 climb again");
    rd_mask(1, "R5 read at 4");
    rd_mask(1, "R5 after rearm");

    // other port clears the run
    rd_mask(2, "R7 partial");
    drive(1'b0, 1'b1, 2'd3, 8'h11, "R7 data write");
    rd_mask(4, "R7 after data write");
    rd_mask(3, "R7 partial");
    drive(1'b1, 1'b0, 2'd2, 8'h00, "R7 write-index read");
    rd_mask(4, "R7 after index read");
    drive(1'b0, 1'b1, 2'd1, 8'h22, "R7 read-index write");
    rd_mask(3, "R7 after index write");

    // mask write below the limit
    drive(1'b0, 1'b1, 2'd0, 8'h77, "R9");
    check_regs("R9 write at count 3");
    rd_mask(4, "R9 run restarts");
    drive(1'b1, 1'b0, 2'd3, 8'h00, "R7 data read");

    // sticky variant
    set_mode(1'b1, 1'b1);
    rd_mask(4, "R6 climb");
    rd_mask(5, "R6 held at 4");
    drive(1'b0, 1'b1, 2'd0, 8'h5A, "R8");
    check_regs("R8 sticky hidden write");
    rd_mask(4, "R6 after write clears");

    // locking while armed keeps the mask port plain
    set_mode(1'b0, 1'b1);
    rd_mask(2, "R3 locked while armed");
    drive(1'b0, 1'b1, 2'd0, 8'h96, "R9");
    check_regs("R9 locked write");

    idle();
    idle();
    n_cmp++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard drain: actual %0d expected 0", sb.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule